// File: doc/BRIEF.md
# Request-Gated Differential Clock Stopper

This block sits between a running SRC reference clock and a bank of differential clock lanes. Each lane carries a true level, a complement level and an output enable. The output enable decides whether the lane is driven or left floating. Two active-low request pins, A and B, let downstream agents ask for their clocks to be parked. Per-lane configuration bits say whether a lane is stoppable and, if it is, which of the two pins controls it. Free-running lanes ignore both pins.

Everything runs on a fast reference clock. The SRC clock enters as a level that is synchronous to the reference clock. Each lane's true output reproduces that level one reference cycle late. This gives the block one cycle of lookahead on every SRC edge.

A lane is parked only on the reference edge where its true output falls. Parking drops the enable, so the lane ends low and floats. Restart is counted in whole SRC rising edges after the synchronized release. The enable returns one reference cycle before the first true-clock high phase. Every lane parked by the released pin comes back on that same edge.

Top module: `clkreq_src_gater`

## Requirements
- R1: During reset every lane has out_oe = 1, out_true = 0 and out_comp = 1.
- R2: A lane whose cfg_stoppable bit is 0 keeps out_oe = 1 whatever the request pins do. Its out_true equals the SRC level sampled at the previous reference edge.
- R3: While out_oe of a lane is 1, its out_comp is the inverse of its out_true.
- R4: Each request pin passes through SYNC_STAGES flops. A stoppable lane mapped to a pin held high stops at the first reference edge, no earlier than SYNC_STAGES+1 edges after the pin rose, on which its out_true would fall from 1 to 0. At that edge out_oe falls.
- R5: While out_oe of a lane is 0, both out_true and out_comp are 0.
- R6: The pin mapping is cfg_use_b = 0 for pin A and cfg_use_b = 1 for pin B. A lane whose pin is not asserted, or which is not stoppable, keeps out_oe = 1 and keeps toggling.
- R7: After a pin returns low, SRC rising edges are counted from the (SYNC_STAGES+1)-th reference edge onward. Rising edges are counted in the reference domain. The parked lanes of that pin resume on the RESUME_RISES-th such edge. With the defaults and an SRC period of eight reference cycles, the first true high follows the release by 2 to 6 SRC periods.
- R8: On resume, out_oe rises one reference cycle before out_true first goes high. Every high phase of out_true while driven lasts a full SRC half-period.
- R9: All lanes parked by a released pin resume on the same reference edge. Lanes of both pins resume together when both pins are released in the same cycle.
- R10: If the pin is reasserted before the resume edge, the pending restart is cancelled and the lanes stay parked until the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to ref_clk |
| src_clk_in | input | 1 | Running SRC clock level, synchronous to ref_clk |
| req_a_n | input | 1 | Active-low clock request pin A (high asks for a stop) |
| req_b_n | input | 1 | Active-low clock request pin B (high asks for a stop) |
| cfg_stoppable | input | NUM_OUT | Per lane: 1 lets a request park the lane |
| cfg_use_b | input | NUM_OUT | Per lane: 0 selects pin A, 1 selects pin B |
| out_true | output | NUM_OUT | True clock level per lane |
| out_comp | output | NUM_OUT | Complement clock level per lane |
| out_oe | output | NUM_OUT | Output enable per lane; 0 means the lane floats |

## Verification
The bench runs four lane-to-pin mappings. For each mapping it asserts pin A, pin B and both pins at all eight SRC phase offsets. From the SRC waveform it computes the exact reference edge on which each lane should park and the edge on which it should come back.

A design that parks on the wrong edge shows up in two ways: the enable drops while the true level is still high, or the bench sees a high phase shorter than four cycles. A design that counts the wrong number of rises, or forgets the synchronizer latency, misses the computed resume edge. So does one that raises the enable together with the true clock.

A separate case releases a pin and then reasserts it in mid-countdown. A timer that does not clear would bring the lanes back. The per-cycle monitor catches complement errors, levels left high while floating, and free-running lanes that react to a request.

// File: rtl/clkreq_gate_pkg.sv
package clkreq_gate_pkg;

   // Per-lane operating mode: toggling with the SRC clock, or parked and floating
   typedef enum logic {
      LANE_TOGGLE = 1'b0,
      LANE_PARKED = 1'b1
   } lane_mode_e;

   // Index of each request pin in the group vectors
   localparam int PIN_A   = 0;
   localparam int PIN_B   = 1;
   localparam int NUM_PIN = 2;

endpackage

// File: rtl/req_synchronizer.sv
module req_synchronizer #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_async,
   output logic halt_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("req_synchronizer: STAGES must be at least 2");
      end

      if (STAGES == 2) begin : g_pair
         logic meta_q;
         logic stable_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               meta_q   <= 1'b0;
               stable_q <= 1'b0;
            end else begin
               meta_q   <= req_n_async;
               stable_q <= meta_q;
            end
         end

         assign halt_sync = stable_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], req_n_async};
            end
         end

         assign halt_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/src_edge_tracker.sv
module src_edge_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic src_level,
   output logic src_q,
   output logic src_rise
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= 1'b0;
      end else begin
         src_q <= src_level;
      end
   end

   // A rise seen on the raw level is one reference cycle ahead of the lanes
   assign src_rise = src_level & ~src_q;

endmodule

// File: rtl/resume_timer.sv
module resume_timer #(
   parameter int RISES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt,
   input  logic src_rise,
   output logic go
);

   localparam int CW = $clog2(RISES + 1);
   localparam logic [CW-1:0] LAST = CW'(RISES - 1);
   localparam logic [CW-1:0] DONE = CW'(RISES);

   logic [CW-1:0] seen_q;

   generate
      if (RISES < 1) begin : g_bad_rises
         $error("resume_timer: RISES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (halt) begin
         seen_q <= '0;
      end else if (src_rise && (seen_q != DONE)) begin
         seen_q <= seen_q + 1'b1;
      end
   end

   assign go = ~halt & src_rise & (seen_q == LAST);

endmodule

// File: rtl/lane_gate.sv
module lane_gate
   import clkreq_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stoppable,
   input  logic halt,
   input  logic go,
   input  logic src_q,
   output logic lane_true,
   output logic lane_comp,
   output logic lane_oe
);

   lane_mode_e mode_q;
   logic       park_now;

   // Park only where the true level is about to fall
   assign park_now = stoppable & halt & lane_true & ~src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= LANE_TOGGLE;
         lane_true <= 1'b0;
         lane_comp <= 1'b1;
         lane_oe   <= 1'b1;
      end else begin
         case (mode_q)
            LANE_TOGGLE: begin
               if (park_now) begin
                  mode_q    <= LANE_PARKED;
                  lane_true <= 1'b0;
                  lane_comp <= 1'b0;
                  lane_oe   <= 1'b0;
               end else begin
                  lane_true <= src_q;
                  lane_comp <= ~src_q;
               end
            end
            LANE_PARKED: begin
               if (go) begin
                  mode_q    <= LANE_TOGGLE;
                  lane_true <= 1'b0;
                  lane_comp <= 1'b1;
                  lane_oe   <= 1'b1;
               end
            end
            default: begin
               mode_q <= LANE_TOGGLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/clkreq_src_gater.sv
module clkreq_src_gater
   import clkreq_gate_pkg::*;
#(
   parameter int NUM_OUT      = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int RESUME_RISES = 3
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic               src_clk_in,
   input  logic               req_a_n,
   input  logic               req_b_n,
   input  logic [NUM_OUT-1:0] cfg_stoppable,
   input  logic [NUM_OUT-1:0] cfg_use_b,
   output logic [NUM_OUT-1:0] out_true,
   output logic [NUM_OUT-1:0] out_comp,
   output logic [NUM_OUT-1:0] out_oe
);

   generate
      if (NUM_OUT < 1) begin : g_bad_width
         $error("clkreq_src_gater: NUM_OUT must be at least 1");
      end
      if ((RESUME_RISES < 2) || (RESUME_RISES > 5)) begin : g_bad_rises
         $error("clkreq_src_gater: RESUME_RISES must lie in 2..5");
      end
   endgenerate

   logic [NUM_PIN-1:0] pin_req_n;
   logic [NUM_PIN-1:0] pin_halt;
   logic [NUM_PIN-1:0] pin_go;
   logic               src_q;
   logic               src_rise;

   assign pin_req_n[PIN_A] = req_a_n;
   assign pin_req_n[PIN_B] = req_b_n;

   src_edge_tracker u_edge (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .src_level (src_clk_in),
      .src_q     (src_q),
      .src_rise  (src_rise)
   );

   for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      req_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
         .clk         (ref_clk),
         .rst_n       (rst_n),
         .req_n_async (pin_req_n[p]),
         .halt_sync   (pin_halt[p])
      );

      resume_timer #(.RISES(RESUME_RISES)) u_timer (
         .clk      (ref_clk),
         .rst_n    (rst_n),
         .halt     (pin_halt[p]),
         .src_rise (src_rise),
         .go       (pin_go[p])
      );
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
      logic lane_halt;
      logic lane_go;

      assign lane_halt = cfg_use_b[i] ? pin_halt[PIN_B] : pin_halt[PIN_A];
      assign lane_go   = cfg_use_b[i] ? pin_go[PIN_B]   : pin_go[PIN_A];

      lane_gate u_lane (
         .clk       (ref_clk),
         .rst_n     (rst_n),
         .stoppable (cfg_stoppable[i]),
         .halt      (lane_halt),
         .go        (lane_go),
         .src_q     (src_q),
         .lane_true (out_true[i]),
         .lane_comp (out_comp[i]),
         .lane_oe   (out_oe[i])
      );
   end

endmodule

// File: rtl/clkreq_src_gater_chk.sv
module clkreq_src_gater_chk #(
   parameter int NUM_OUT = 8
) (
   input logic               ref_clk,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] cfg_stoppable,
   input logic [NUM_OUT-1:0] out_true,
   input logic [NUM_OUT-1:0] out_comp,
   input logic [NUM_OUT-1:0] out_oe
);

   // R2: a lane that cannot be stopped is always driven
   p_free_driven_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ((out_oe | cfg_stoppable) == {NUM_OUT{1'b1}}));

   // R3: driven lanes carry opposite levels on the pair
   p_pair_opposite_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (((out_true ^ out_comp) | ~out_oe) == {NUM_OUT{1'b1}}));

   // R5: a floating lane holds both levels low
   p_parked_low_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (((out_true | out_comp) & ~out_oe) == {NUM_OUT{1'b0}}));

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane_chk
      // R4: enable drops only where the true level had been high
      p_park_after_high_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
         $fell(out_oe[i]) |-> $past(out_true[i]));

      // R8: enable comes back while the true level is still low
      p_oe_leads_low_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
         $rose(out_oe[i]) |-> !out_true[i]);

      // R8: the first high follows the enable by exactly one cycle
      p_oe_leads_high_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
         $rose(out_oe[i]) |=> out_true[i]);
   end

endmodule

bind clkreq_src_gater clkreq_src_gater_chk #(.NUM_OUT(NUM_OUT)) u_chk (
   .ref_clk       (ref_clk),
   .rst_n         (rst_n),
   .cfg_stoppable (cfg_stoppable),
   .out_true      (out_true),
   .out_comp      (out_comp),
   .out_oe        (out_oe)
);

// File: tb/clkreq_src_gater_bench.sv
`timescale 1ns/1ps
module clkreq_src_gater_bench;

   localparam int N     = 4;
   localparam int HALF  = 4;
   localparam int PER   = 8;
   localparam int PH    = 3;
   localparam int SYNC  = 2;
   localparam int RISES = 3;

   logic         clk     = 1'b0;
   logic         rst_n   = 1'b0;
   logic         src     = 1'b0;
   logic         req_a_n = 1'b0;
   logic         req_b_n = 1'b0;
   logic [N-1:0] cfg_stop = '0;
   logic [N-1:0] cfg_b    = '0;
   logic [N-1:0] ot, oc, oe;

   int pcount = 0;
   int n_cmp  = 0;
   int n_bad  = 0;
   bit mon_on = 1'b0;
   int run_len [N];

   clkreq_src_gater #(.NUM_OUT(N)) u_clkreq_src_gater (
      .ref_clk       (clk),
      .rst_n         (rst_n),
      .src_clk_in    (src),
      .req_a_n       (req_a_n),
      .req_b_n       (req_b_n),
      .cfg_stoppable (cfg_stop),
      .cfg_use_b     (cfg_b),
      .out_true      (ot),
      .out_comp      (oc),
      .out_oe        (oe)
   );

   always #4 clk = ~clk;

   always @(posedge clk) pcount <= pcount + 1;

   // SRC level that the posedge numbered p samples
   function automatic bit src_at(int p);
      return ((p + PH) % PER) < HALF;
   endfunction

   always @(negedge clk) src <= src_at(pcount + 1);

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, pcount);
      end
   endtask

   // First posedge >= from at which the true output would fall
   function automatic int first_fall(int from);
      int p = from;
      while (!(src_at(p - 2) && !src_at(p - 1))) p++;
      return p;
   endfunction

   // Posedge of the k-th raw SRC rise seen at or after from
   function automatic int nth_rise(int from, int k);
      int p = from;
      int seen = 0;
      forever begin
         if (src_at(p) && !src_at(p - 1)) begin
            seen++;
            if (seen == k) return p;
         end
         p++;
      end
   endfunction

   task automatic wait_to(int x);
      while (pcount < x) @(negedge clk);
   endtask

   // Per-cycle monitor: R2, R3, R5 and full high-phase width (R8)
   always @(negedge clk) begin
      if (mon_on) begin
         for (int i = 0; i < N; i++) begin
            if (oe[i]) chk(oc[i] == ~ot[i], "R3", "complement", oc[i], ~ot[i]);
            else       chk(!ot[i] && !oc[i], "R5", "parked levels", {ot[i], oc[i]}, 0);
            if (!cfg_stop[i])
               chk(oe[i] && (ot[i] == src_at(pcount - 1)), "R2", "free lane level",
                   {oe[i], ot[i]}, {1'b1, src_at(pcount - 1)});
            if (oe[i] && ot[i]) begin
               if (run_len[i] >= 0) run_len[i]++;
            end else begin
               if (run_len[i] > 0) chk(run_len[i] == HALF, "R8", "high phase width", run_len[i], HALF);
               run_len[i] = 0;
            end
         end
      end
   end

   task automatic release_pins(bit ua, bit ub, logic [N-1:0] aff);
      int r, g;
      r = pcount;
      if (ua) req_a_n = 1'b0;
      if (ub) req_b_n = 1'b0;
      g = nth_rise(r + SYNC + 1, RISES);
      wait_to(g - 1);
      chk((oe & aff) == '0, "R7", "still parked before resume edge", oe, 0);
      wait_to(g);
      chk((oe & aff) == aff, "R8", "enable back at resume edge", oe & aff, aff);
      chk((ot & aff) == '0, "R8", "true low while enable returns", ot & aff, 0);
      wait_to(g + 1);
      chk((ot & aff) == aff, "R9", "all parked lanes high together", ot & aff, aff);
      chk((g + 1 - r >= 2 * PER) && (g + 1 - r <= 6 * PER), "R7", "restart latency", g + 1 - r, 2 * PER);
      wait_to(g + PER + 2);
   endtask

   task automatic park_pins(bit ua, bit ub, int skew, output logic [N-1:0] aff, output int sp);
      int n;
      repeat (skew + 1) @(negedge clk);
      aff = cfg_stop & ((ua ? ~cfg_b : '0) | (ub ? cfg_b : '0));
      n = pcount;
      if (ua) req_a_n = 1'b1;
      if (ub) req_b_n = 1'b1;
      sp = first_fall(n + SYNC + 1);
      wait_to(sp - 1);
      chk((oe & aff) == aff, "R4", "driven before park edge", oe & aff, aff);
      wait_to(sp);
      chk((oe & aff) == '0, "R4", "parked on falling edge", oe & aff, 0);
      chk((oe & ~aff) == ~aff, "R6", "other lanes unaffected", oe & ~aff, ~aff);
   endtask

   task automatic run_case(bit ua, bit ub, int skew);
      logic [N-1:0] aff;
      int sp;
      park_pins(ua, ub, skew, aff, sp);
      wait_to(sp + 5);
      release_pins(ua, ub, aff);
   endtask

   task automatic cancel_case();
      logic [N-1:0] aff;
      int sp, r, g;
      park_pins(1'b1, 1'b0, 0, aff, sp);
      wait_to(sp + 5);
      r = pcount;
      req_a_n = 1'b0;
      g = nth_rise(r + SYNC + 1, RISES);
      wait_to(r + 4);
      req_a_n = 1'b1;
      wait_to(g + 2);
      chk((oe & aff) == '0, "R10", "restart cancelled", oe & aff, 0);
      wait_to(g + PER);
      chk((oe & aff) == '0, "R10", "lanes stay parked", oe & aff, 0);
      release_pins(1'b1, 1'b0, aff);
   endtask

   initial begin
      logic [N-1:0] stop_tab [4];
      logic [N-1:0] b_tab [4];
      stop_tab[0] = 4'b1110; b_tab[0] = 4'b0100;
      stop_tab[1] = 4'b1011; b_tab[1] = 4'b1010;
      stop_tab[2] = 4'b0101; b_tab[2] = 4'b0001;
      stop_tab[3] = 4'b1111; b_tab[3] = 4'b0000;
      for (int i = 0; i < N; i++) run_len[i] = -1;
      cfg_stop = stop_tab[0];
      cfg_b    = b_tab[0];
      repeat (3) @(negedge clk);
      chk(oe == '1, "R1", "reset enable", oe, 4'hf);
      chk(ot == '0, "R1", "reset true", ot, 0);
      chk(oc == '1, "R1", "reset complement", oc, 4'hf);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mon_on = 1'b1;
      for (int c = 0; c < 4; c++) begin
         cfg_stop = stop_tab[c];
         cfg_b    = b_tab[c];
         for (int s = 0; s < PER; s++) begin
            run_case(1'b1, 1'b0, s);
            run_case(1'b0, 1'b1, s);
            run_case(1'b1, 1'b1, s);
         end
         cancel_case();
      end
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule